// File: doc/BRIEF.md
# Contactless card session controller

This block is the protocol core of a contactless card. It sits between the demodulator that delivers reader frames and the transmitter that sends responses. A byte memory hangs off its memory port. Each reader frame arrives as a one-cycle strobe. The strobe carries the frame bits (the first bit received sits in bit 0), the number of bits, and an error flag raised on a code violation or a timeout. The controller answers with transmit requests. It drives a seed load for the keystream generator and a timestamp nudge for the slot timer.

A session begins with a three-step handshake. First the reader sends a 7-bit seed. The card then answers with a 6-bit code for its type. Finally the reader confirms with a 6-bit acknowledge. Once linked, the controller serves commands until a frame it cannot accept drops it back to idle. Commands carry no opcode: a read and a write are told apart only by frame length, and that length depends on the configured card type. A 4-bit CRC covers the command bits together with the data byte. The CRC is computed one bit per clock.

Top module: `card_session_ctrl`

## Requirements
- R1: After reset, `linked`, `cfg_err`, `tx_req`, `tx_ack`, `seed_load`, `ts_bump`, `mem_rd_en` and `mem_we` are all low.
- R2: In idle, an error-free 7-bit frame produces one `seed_load` pulse, with `seed_val` equal to frame bits 6:0. In the same cycle it produces a `tx_req` with `tx_len` = 6. A frame of any other length, or a flagged frame, leaves the controller idle with no output.
- R3: After the type reply, an error-free 6-bit frame equal to 0x19 (type 0) or 0x39 (types 1 and 2) sets `linked` and pulses `ts_bump` with `ts_bump_ticks` = 21. Any other frame returns the controller to idle without `ts_bump`.
- R4: The type reply in `tx_data` is 0x0D for type 0, 0x1D for type 1 and 0x3D for type 2. The command, address and memory sizes are 6/5/22 for type 0, 9/8/256 for type 1 and 11/10/1024 for type 2.
- R5: While linked, a frame whose length equals the command size is a read. The address is the command shifted right by one. The reply is a 12-bit `tx_req`: the stored byte in bits 7:0 and the CRC in bits 11:8.
- R6: While linked, a frame of command size + 12 bits is a write. The address is frame bits [address size:1]. The byte follows the command bits, and the 4-bit CRC follows the byte. On a CRC match, the byte is written with one `mem_we` pulse, the same cycle also pulses `tx_ack`, and the controller stays linked.
- R7: A write whose received CRC differs from the computed one writes nothing, sends nothing, and returns the controller to idle.
- R8: While linked, a flagged frame or a frame of any other length returns the controller to idle.
- R9: The CRC starts at 0x5. For each input bit b, taken least significant bit first, the state shifts right by one and is XORed with 0xC when the old state bit 0 XOR b is 1. For a read, the input is (byte << command size) | command. For a write, the input is (byte << command size) | (address << 1). In both cases it covers 8 + command size bits.
- R10: A card type of 3 raises `cfg_err`, holds the controller in idle and ignores all frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| card_type | input | 2 | Configured card type 0..2 |
| rx_valid | input | 1 | One-cycle strobe: received frame present |
| rx_err | input | 1 | Frame ended in a code violation or a timeout |
| rx_len | input | 5 | Number of bits in the frame |
| rx_data | input | 23 | Frame bits, first received in bit 0 |
| seed_load | output | 1 | Load the keystream seed |
| seed_val | output | 7 | Seed value |
| tx_req | output | 1 | Transmit a keystream-covered frame |
| tx_len | output | 4 | Bits to transmit |
| tx_data | output | 12 | Bits to transmit, bit 0 first |
| tx_ack | output | 1 | Transmit the plain write acknowledge |
| ts_bump | output | 1 | Advance the frame-end timestamp |
| ts_bump_ticks | output | 8 | Advance amount in timer ticks |
| mem_rd_en | output | 1 | Memory read strobe (data expected next cycle) |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 10 | Memory address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte |
| linked | output | 1 | Session linked and awaiting a command |
| cfg_err | output | 1 | Card type is not supported |

## Verification
Every cycle, the checker confirms several pairings. A seed load always comes with a 6-bit reply. A timestamp nudge always lands in the linked state and carries 21 ticks. Linked replies are 12 bits long. Writes and acknowledges always occur together. A flagged frame always ends the session. A bad type never allows a link or any output. Only the bench scenarios can show that the values are right: reply codes per type, read bytes and their CRC, memory contents after good and corrupted writes, and the rejection of unsupported lengths. The bench checks these against a reference memory and a CRC function of its own.

// File: rtl/card_session_pkg.sv
package card_session_pkg;

   typedef struct packed {
      logic       ok;
      logic [3:0] cmd_bits;
      logic [3:0] addr_bits;
      logic [5:0] type_code;
      logic [5:0] ack_code;
   } geom_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HSACK,
      ST_LINK,
      ST_RDREQ,
      ST_RDCAP,
      ST_CRC
   } sess_t;

   localparam logic [3:0] CRC_SEED = 4'h5;
   localparam logic [3:0] CRC_POLY = 4'hC;

   // one LSB-first shift of the right-shifting CRC register
   function automatic logic [3:0] crc_step(input logic [3:0] s, input logic b);
      logic [3:0] n;
      n = {1'b0, s[3:1]};
      if (s[0] ^ b)
         n = n ^ CRC_POLY;
      return n;
   endfunction

   function automatic logic [3:0] crc_over(input logic [31:0] w, input int n);
      logic [3:0] s;
      s = CRC_SEED;
      for (int i = 0; i < 32; i++)
         if (i < n)
            s = crc_step(s, w[i]);
      return s;
   endfunction

endpackage

// File: rtl/card_geometry.sv
module card_geometry
   import card_session_pkg::*;
(
   input  logic [1:0] card_type,
   output geom_t      geom
);

   always_comb begin
      case (card_type)
         2'd0:    geom = '{ok: 1'b1, cmd_bits: 4'd6,  addr_bits: 4'd5,
                           type_code: 6'h0D, ack_code: 6'h19};
         2'd1:    geom = '{ok: 1'b1, cmd_bits: 4'd9,  addr_bits: 4'd8,
                           type_code: 6'h1D, ack_code: 6'h39};
         2'd2:    geom = '{ok: 1'b1, cmd_bits: 4'd11, addr_bits: 4'd10,
                           type_code: 6'h3D, ack_code: 6'h39};
         default: geom = '{ok: 1'b0, cmd_bits: 4'd0,  addr_bits: 4'd0,
                           type_code: 6'h00, ack_code: 6'h00};
      endcase
   end

endmodule

// File: rtl/crc4_unit.sv
module crc4_unit
   import card_session_pkg::*;
#(
   parameter  int W      = 19,
   parameter  bit SERIAL = 1'b1,
   localparam int NW     = $clog2(W + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [W-1:0]  din,
   input  logic [NW-1:0] nbits,
   output logic          done,
   output logic [3:0]    crc
);

   initial begin
      assert (W >= 1 && W <= 32) else $error("crc4_unit: W out of range");
   end

   generate
      if (SERIAL) begin : g_serial
         logic [W-1:0]  sh;
         logic [NW-1:0] left;
         logic          run;
         logic          fin;
         logic [3:0]    st;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sh   <= '0;
               left <= '0;
               run  <= 1'b0;
               fin  <= 1'b0;
               st   <= CRC_SEED;
            end else begin
               fin <= 1'b0;
               if (start) begin
                  sh   <= din;
                  left <= nbits;
                  st   <= CRC_SEED;
                  run  <= (nbits != '0);
               end else if (run) begin
                  st   <= crc_step(st, sh[0]);
                  sh   <= sh >> 1;
                  left <= left - 1'b1;
                  if (left == NW'(1)) begin
                     run <= 1'b0;
                     fin <= 1'b1;
                  end
               end
            end
         end

         assign done = fin;
         assign crc  = st;
      end else begin : g_flat
         logic       fin;
         logic [3:0] st;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               fin <= 1'b0;
               st  <= CRC_SEED;
            end else begin
               fin <= start;
               if (start)
                  st <= crc_over(32'(din), int'(nbits));
            end
         end

         assign done = fin;
         assign crc  = st;
      end
   endgenerate

endmodule

// File: rtl/card_session_ctrl.sv
module card_session_ctrl
   import card_session_pkg::*;
#(
   parameter int FRAME_W    = 23,
   parameter int LEN_W      = 5,
   parameter int ADDR_W     = 10,
   parameter int TICK_W     = 8,
   parameter int BIT_TICKS  = 21,
   parameter bit CRC_SERIAL = 1'b1,
   localparam int SEED_W    = 7,
   localparam int TXW       = 12,
   localparam int TXL_W     = $clog2(TXW + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         card_type,
   input  logic               rx_valid,
   input  logic               rx_err,
   input  logic [LEN_W-1:0]   rx_len,
   input  logic [FRAME_W-1:0] rx_data,
   output logic               seed_load,
   output logic [SEED_W-1:0]  seed_val,
   output logic               tx_req,
   output logic [TXL_W-1:0]   tx_len,
   output logic [TXW-1:0]     tx_data,
   output logic               tx_ack,
   output logic               ts_bump,
   output logic [TICK_W-1:0]  ts_bump_ticks,
   output logic               mem_rd_en,
   output logic               mem_we,
   output logic [ADDR_W-1:0]  mem_addr,
   output logic [7:0]         mem_wdata,
   input  logic [7:0]         mem_rdata,
   output logic               linked,
   output logic               cfg_err
);

   localparam int DATA_W  = 8;
   localparam int CRC_W   = 4;
   localparam int HS_BITS = 6;
   localparam int CW      = FRAME_W - CRC_W;
   localparam int NW      = $clog2(CW + 1);

   initial begin
      assert (FRAME_W >= 23 && FRAME_W <= 32) else $error("FRAME_W must hold 11+12 bits");
      assert (ADDR_W >= 10) else $error("ADDR_W too small for type 2");
      assert ((1 << LEN_W) > FRAME_W) else $error("LEN_W too small");
      assert (BIT_TICKS < (1 << TICK_W)) else $error("TICK_W too small");
   end

   geom_t g;
   card_geometry u_geom (.card_type(card_type), .geom(g));

   // field extraction for the configured geometry
   logic [FRAME_W-1:0] cmd_mask, addr_mask, rx_cmd, rx_addr;
   logic [DATA_W-1:0]  rx_byte;
   logic [CRC_W-1:0]   rx_crc;
   logic [4:0]         dat_end;
   logic               len_read, len_write;

   always_comb begin
      cmd_mask  = (FRAME_W'(1) << g.cmd_bits) - FRAME_W'(1);
      addr_mask = (FRAME_W'(1) << g.addr_bits) - FRAME_W'(1);
      rx_cmd    = rx_data & cmd_mask;
      rx_addr   = (rx_data >> 1) & addr_mask;
      dat_end   = 5'(g.cmd_bits) + 5'(DATA_W);
      rx_byte   = DATA_W'(rx_data >> g.cmd_bits);
      rx_crc    = CRC_W'(rx_data >> dat_end);
      len_read  = (rx_len == LEN_W'(g.cmd_bits));
      len_write = (rx_len == LEN_W'(g.cmd_bits) + LEN_W'(DATA_W + CRC_W));
   end

   // CRC engine
   logic            crc_start, crc_done;
   logic [CW-1:0]   crc_word;
   logic [NW-1:0]   crc_n;
   logic [CRC_W-1:0] crc_val;

   assign crc_n = NW'(g.cmd_bits) + NW'(DATA_W);

   crc4_unit #(.W(CW), .SERIAL(CRC_SERIAL)) u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .start (crc_start),
      .din   (crc_word),
      .nbits (crc_n),
      .done  (crc_done),
      .crc   (crc_val)
   );

   sess_t              state;
   logic [FRAME_W-1:0] cmd_q;
   logic [DATA_W-1:0]  byte_q;
   logic [CRC_W-1:0]   crc_rx_q;
   logic               is_wr_q;

   assign linked        = (state == ST_LINK);
   assign ts_bump_ticks = TICK_W'(BIT_TICKS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         seed_load <= 1'b0;
         seed_val  <= '0;
         tx_req    <= 1'b0;
         tx_len    <= '0;
         tx_data   <= '0;
         tx_ack    <= 1'b0;
         ts_bump   <= 1'b0;
         mem_rd_en <= 1'b0;
         mem_we    <= 1'b0;
         mem_addr  <= '0;
         mem_wdata <= '0;
         cfg_err   <= 1'b0;
         cmd_q     <= '0;
         byte_q    <= '0;
         crc_rx_q  <= '0;
         is_wr_q   <= 1'b0;
         crc_start <= 1'b0;
         crc_word  <= '0;
      end else begin
         seed_load <= 1'b0;
         tx_req    <= 1'b0;
         tx_ack    <= 1'b0;
         ts_bump   <= 1'b0;
         mem_rd_en <= 1'b0;
         mem_we    <= 1'b0;
         crc_start <= 1'b0;
         cfg_err   <= !g.ok;
         if (!g.ok) begin
            state <= ST_IDLE;
         end else begin
            case (state)
               ST_IDLE: begin
                  if (rx_valid && !rx_err && rx_len == LEN_W'(SEED_W)) begin
                     seed_load <= 1'b1;
                     seed_val  <= rx_data[SEED_W-1:0];
                     tx_req    <= 1'b1;
                     tx_len    <= TXL_W'(HS_BITS);
                     tx_data   <= TXW'(g.type_code);
                     state     <= ST_HSACK;
                  end
               end
               ST_HSACK: begin
                  if (rx_valid) begin
                     if (!rx_err && rx_len == LEN_W'(HS_BITS) &&
                         rx_data[HS_BITS-1:0] == g.ack_code) begin
                        ts_bump <= 1'b1;
                        state   <= ST_LINK;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
               ST_LINK: begin
                  if (rx_valid) begin
                     if (rx_err) begin
                        state <= ST_IDLE;
                     end else if (len_read) begin
                        cmd_q     <= rx_cmd;
                        mem_addr  <= ADDR_W'(rx_addr);
                        mem_rd_en <= 1'b1;
                        state     <= ST_RDREQ;
                     end else if (len_write) begin
                        mem_addr  <= ADDR_W'(rx_addr);
                        mem_wdata <= rx_byte;
                        crc_rx_q  <= rx_crc;
                        crc_word  <= (CW'(rx_byte) << g.cmd_bits) | CW'(rx_addr << 1);
                        crc_start <= 1'b1;
                        is_wr_q   <= 1'b1;
                        state     <= ST_CRC;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
               ST_RDREQ: begin
                  state <= ST_RDCAP;
               end
               ST_RDCAP: begin
                  byte_q    <= mem_rdata;
                  crc_word  <= (CW'(mem_rdata) << g.cmd_bits) | CW'(cmd_q);
                  crc_start <= 1'b1;
                  is_wr_q   <= 1'b0;
                  state     <= ST_CRC;
               end
               ST_CRC: begin
                  if (crc_done) begin
                     if (!is_wr_q) begin
                        tx_req  <= 1'b1;
                        tx_len  <= TXL_W'(TXW);
                        tx_data <= {crc_val, byte_q};
                        state   <= ST_LINK;
                     end else if (crc_val == crc_rx_q) begin
                        mem_we <= 1'b1;
                        tx_ack <= 1'b1;
                        state  <= ST_LINK;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/card_session_chk.sv
module card_session_chk #(
   parameter int TXL_W     = 4,
   parameter int TICK_W    = 8,
   parameter int BIT_TICKS = 21
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_valid,
   input logic              rx_err,
   input logic              seed_load,
   input logic              tx_req,
   input logic [TXL_W-1:0]  tx_len,
   input logic              tx_ack,
   input logic              ts_bump,
   input logic [TICK_W-1:0] ts_bump_ticks,
   input logic              mem_rd_en,
   input logic              mem_we,
   input logic              linked,
   input logic              cfg_err
);

   assert_seed_with_reply_R2: assert property (@(posedge clk) disable iff (!rst_n)
      seed_load |-> (tx_req && tx_len == TXL_W'(6) && !linked));

   assert_bump_links_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ts_bump |-> (linked && ts_bump_ticks == TICK_W'(BIT_TICKS)));

   assert_read_reply_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_req && linked) |-> tx_len == TXL_W'(12));

   assert_read_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |=> !mem_rd_en);

   assert_write_acked_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (tx_ack && linked));

   assert_ack_needs_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ack |-> mem_we);

   assert_err_drops_link_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (linked && rx_valid && rx_err) |=> !linked);

   assert_bad_type_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> (!linked && !tx_req && !mem_we && !seed_load));

endmodule

bind card_session_ctrl card_session_chk #(
   .TXL_W(TXL_W), .TICK_W(TICK_W), .BIT_TICKS(BIT_TICKS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_err(rx_err),
   .seed_load(seed_load), .tx_req(tx_req), .tx_len(tx_len), .tx_ack(tx_ack),
   .ts_bump(ts_bump), .ts_bump_ticks(ts_bump_ticks), .mem_rd_en(mem_rd_en),
   .mem_we(mem_we), .linked(linked), .cfg_err(cfg_err)
);

// File: tb/tb_card_session_ctrl.sv
module tb_card_session_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  card_type = 2'd0;
   logic        rx_valid = 1'b0, rx_err = 1'b0;
   logic [4:0]  rx_len = '0;
   logic [22:0] rx_data = '0;
   logic        seed_load, tx_req, tx_ack, ts_bump, mem_rd_en, mem_we, linked, cfg_err;
   logic [6:0]  seed_val;
   logic [3:0]  tx_len;
   logic [11:0] tx_data;
   logic [7:0]  ts_bump_ticks, mem_wdata;
   logic [7:0]  mem_rdata = '0;
   logic [9:0]  mem_addr;

   always #10 clk = ~clk;

   card_session_ctrl dut (
      .clk(clk), .rst_n(rst_n), .card_type(card_type), .rx_valid(rx_valid),
      .rx_err(rx_err), .rx_len(rx_len), .rx_data(rx_data), .seed_load(seed_load),
      .seed_val(seed_val), .tx_req(tx_req), .tx_len(tx_len), .tx_data(tx_data),
      .tx_ack(tx_ack), .ts_bump(ts_bump), .ts_bump_ticks(ts_bump_ticks),
      .mem_rd_en(mem_rd_en), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .linked(linked), .cfg_err(cfg_err)
   );

   // memory behind the port, and the bench's own expectation of it
   logic [7:0] mem [1024];
   logic [7:0] ref_mem [1024];
   always @(posedge clk) begin
      if (mem_rd_en) mem_rdata <= mem[mem_addr];
      if (mem_we) mem[mem_addr] <= mem_wdata;
   end

   int n_chk = 0, n_fail = 0, cyc = 0;
   int n_seed, n_tx, n_ack, n_bump, n_we;
   logic [6:0]  last_seed;
   logic [3:0]  last_len;
   logic [11:0] last_data;
   logic [7:0]  last_ticks;

   always @(negedge clk) if (rst_n) begin
      if (seed_load) begin n_seed++; last_seed = seed_val; end
      if (tx_req) begin n_tx++; last_len = tx_len; last_data = tx_data; end
      if (tx_ack) n_ack++;
      if (ts_bump) begin n_bump++; last_ticks = ts_bump_ticks; end
      if (mem_we) n_we++;
   end

   task automatic summary();
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         summary();
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [3:0] ref_crc(input logic [31:0] w, input int n);
      logic [3:0] s;
      logic fb;
      s = 4'h5;
      for (int i = 0; i < n; i++) begin
         fb = s[0] ^ w[i];
         s  = s >> 1;
         if (fb) s = s ^ 4'hC;
      end
      return s;
   endfunction

   function automatic int cmd_bits(input int t);
      return (t == 0) ? 6 : (t == 1) ? 9 : 11;
   endfunction
   function automatic int mem_size(input int t);
      return (t == 0) ? 22 : (t == 1) ? 256 : 1024;
   endfunction
   function automatic logic [5:0] type_code(input int t);
      return (t == 0) ? 6'h0D : (t == 1) ? 6'h1D : 6'h3D;
   endfunction
   function automatic logic [5:0] ack_code(input int t);
      return (t == 0) ? 6'h19 : 6'h39;
   endfunction

   task automatic clear_ev();
      n_seed = 0; n_tx = 0; n_ack = 0; n_bump = 0; n_we = 0;
   endtask

   task automatic send(input int len, input logic [31:0] data, input bit err);
      @(negedge clk);
      rx_valid = 1'b1; rx_len = 5'(len); rx_data = 23'(data); rx_err = err;
      @(negedge clk);
      rx_valid = 1'b0; rx_err = 1'b0;
      repeat (40) @(negedge clk);
   endtask

   task automatic setup(input int t, input bit good_ack);
      logic [6:0] iv;
      iv = 7'($urandom);
      clear_ev();
      send(7, 32'(iv), 1'b0);
      chk(n_seed == 1 && last_seed == iv, "R2 seed", 32'(last_seed), 32'(iv));
      chk(n_tx == 1 && last_len == 4'd6, "R2 reply length", 32'(last_len), 6);
      chk(last_data == 12'(type_code(t)), "R4 type code", 32'(last_data), 32'(type_code(t)));
      clear_ev();
      send(6, 32'(good_ack ? ack_code(t) : (ack_code(t) ^ 6'h04)), 1'b0);
      if (good_ack) begin
         chk(linked == 1'b1 && n_bump == 1, "R3 linked", 32'(linked), 1);
         chk(last_ticks == 8'd21, "R3 bump ticks", 32'(last_ticks), 21);
      end else begin
         chk(linked == 1'b0 && n_bump == 0, "R3 bad ack", 32'(linked), 0);
      end
   endtask

   task automatic do_read(input int t, input int addr);
      int cb;
      logic [31:0] cmd;
      logic [3:0]  c;
      cb  = cmd_bits(t);
      cmd = (32'(addr) << 1) | 32'd1;
      c   = ref_crc((32'(ref_mem[addr]) << cb) | cmd, 8 + cb);
      clear_ev();
      send(cb, cmd, 1'b0);
      chk(n_tx == 1 && last_len == 4'd12, "R5 read reply", 32'(last_len), 12);
      chk(last_data == {c, ref_mem[addr]}, "R5 R9 read data and crc", 32'(last_data),
          32'({c, ref_mem[addr]}));
   endtask

   task automatic do_write(input int t, input int addr, input logic [7:0] b, input bit bad);
      int cb;
      logic [31:0] cmd, fr;
      logic [3:0]  c;
      cb  = cmd_bits(t);
      cmd = 32'(addr) << 1;
      c   = ref_crc((32'(b) << cb) | cmd, 8 + cb);
      if (bad) c = c ^ 4'h9;
      fr  = (32'(c) << (cb + 8)) | (32'(b) << cb) | cmd;
      clear_ev();
      send(cb + 12, fr, 1'b0);
      if (!bad) begin
         ref_mem[addr] = b;
         chk(n_we == 1 && n_ack == 1 && linked, "R6 write acked", 32'(n_we), 1);
      end else begin
         chk(n_we == 0 && n_ack == 0 && n_tx == 0, "R7 no write", 32'(n_we), 0);
         chk(linked == 1'b0, "R7 back to idle", 32'(linked), 0);
      end
   endtask

   initial begin
      void'($urandom(32'd2024));
      for (int i = 0; i < 1024; i++) begin
         mem[i] = 8'($urandom);
         ref_mem[i] = mem[i];
      end
      clear_ev();
      card_type = 2'd3;
      repeat (3) @(negedge clk);
      chk(!linked && !cfg_err && !tx_req && !tx_ack && !seed_load && !ts_bump &&
          !mem_rd_en && !mem_we, "R1 reset state", 32'(cfg_err), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(cfg_err == 1'b1, "R10 cfg_err", 32'(cfg_err), 1);
      send(7, 32'h55, 1'b0);
      chk(n_seed == 0 && n_tx == 0 && !linked, "R10 frame ignored", 32'(n_seed), 0);

      for (int t = 0; t < 3; t++) begin
         card_type = 2'(t);
         repeat (3) @(negedge clk);
         chk(cfg_err == 1'b0, "R10 cfg_err clears", 32'(cfg_err), 0);
         clear_ev();
         send(5, 32'h1F, 1'b0);
         send(7, 32'h2A, 1'b1);
         chk(n_seed == 0 && n_tx == 0, "R2 wrong or flagged frame ignored", 32'(n_seed), 0);
         setup(t, 1'b0);
         setup(t, 1'b1);
         // boundary addresses, then random traffic
         do_write(t, 0, 8'hA5, 1'b0);
         do_write(t, mem_size(t) - 1, 8'h3C, 1'b0);
         do_read(t, 0);
         do_read(t, mem_size(t) - 1);
         for (int k = 0; k < 14; k++) begin
            int a;
            a = int'($urandom_range(0, mem_size(t) - 1));
            if ($urandom_range(0, 1) == 1) do_write(t, a, 8'($urandom), 1'b0);
            else do_read(t, a);
         end
         // corrupted CRC: nothing stored, session ends
         begin
            int a;
            a = int'($urandom_range(0, mem_size(t) - 1));
            do_write(t, a, ~ref_mem[a], 1'b1);
            setup(t, 1'b1);
            do_read(t, a);
         end
         // unsupported length
         clear_ev();
         send(cmd_bits(t) + 3, 32'h7, 1'b0);
         chk(!linked && n_tx == 0, "R8 odd length drops", 32'(linked), 0);
         // flagged frame
         setup(t, 1'b1);
         clear_ev();
         send(cmd_bits(t), 32'h3, 1'b1);
         chk(!linked && n_tx == 0, "R8 flagged frame drops", 32'(linked), 0);
      end
      summary();
   end

endmodule